// File: doc/BRIEF.md
# Sector Single-Bit ECC Engine

This block builds a 24-bit Hamming-style check code over one flash sector that arrives one byte per valid cycle. Each set data bit folds its 12-bit bit address (byte offset times eight plus bit index) into one parity group, and the complement of that address into a second group. The two groups are packed and inverted, so a sector of all-ones bytes yields an all-ones code and an erased page checks clean against its erased spare bytes.

Once the whole sector has been taken in, the block compares its code with the code stored alongside the sector and classifies the difference. A single flipped data bit gives a difference whose two halves are exact complements; the upper half is then the bit address of the fault. A difference with a single set bit means the stored code was hit, not the data. Everything else is uncorrectable. The classification and the fix location follow the stored-code input combinationally, so a caller can present the stored code at any time and read the verdict once the sector is complete. A start pulse or a take pulse clears the accumulator for the next sector.

Top module: `sec_ecc_engine`

## Requirements
- R1: After reset, sector_done is 0 and calc_code is all ones (the inverted empty accumulator).
- R2: calc_code equals the bitwise inverse of {A, B}, where A (bits 23:12) is the XOR over every 1 data bit of its 12-bit bit address (byte offset in bits 11:3, bit index in bits 2:0) and B (bits 11:0) is the XOR over the same bits of the inverted address.
- R3: A sector of all 0xFF bytes yields calc_code 24'hFFFFFF.
- R4: sector_done becomes 1 in the cycle after the 512th accepted byte and not before; bytes offered while sector_done is 1 leave calc_code unchanged.
- R5: A start or take pulse clears the accumulator and byte count at the next edge (sector_done 0, calc_code all ones); a byte offered in the same cycle is discarded.
- R6: With d = calc_code XOR stored_code, d equal to zero gives result 0 (clean).
- R7: When d[23:12] XOR d[11:0] is 12'hFFF and d[23:15] is below the sector size, result is 1 (data fixed), fix_byte is d[23:15] and fix_bit is d[14:12].
- R8: When d[23:12] XOR d[11:0] is 12'hFFF but d[23:15] is at or beyond the sector size, result is 3 (uncorrectable).
- R9: When d has exactly one bit set, result is 2 (code hit, data intact).
- R10: Any other nonzero d gives result 3; whenever result is not 1, fix_byte and fix_bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new sector; clears accumulator and count |
| take | input | 1 | Result consumed; clears accumulator and count |
| in_valid | input | 1 | in_byte carries a sector byte this cycle |
| in_byte | input | 8 | Sector data byte, in sector order |
| stored_code | input | 24 | Code read back with the sector |
| calc_code | output | 24 | Inverted packed code of the bytes taken so far |
| sector_done | output | 1 | Full sector has been accumulated |
| result | output | 2 | 0 clean, 1 data fixed, 2 code hit, 3 uncorrectable |
| fix_byte | output | 9 | Byte offset to correct when result is 1 |
| fix_bit | output | 3 | Bit index within that byte when result is 1 |

## Verification
A corrupted parity group or byte counter is visible on calc_code one cycle after the offending byte, because the code leaves the accumulator registers with only an inverter between them and the port; a slip of the counter shows either as sector_done asserting on the wrong cycle or as a code mismatch at the end of the sector. Faults in the classifier show the same cycle the stored code is applied, as a wrong result value or a non-zero fix location outside the data-fixed case. Injected single data flips at both ends of the sector, code-only hits at both ends of the code, double faults and an out-of-range fix address on a short-sector build cover each branch.

// File: rtl/sec_ecc_pkg.sv
package sec_ecc_pkg;

   localparam int BYTE_W    = 8;
   localparam int BIT_IDX_W = 3;

   typedef enum logic [1:0] {
      RES_CLEAN    = 2'd0,
      RES_FIXED    = 2'd1,
      RES_CODE_HIT = 2'd2,
      RES_FATAL    = 2'd3
   } ecc_res_e;

endpackage

// File: rtl/sec_ecc_term.sv
// Parity contribution of one byte: every set bit folds its bit address into
// the true group and the inverted address into the complement group.
module sec_ecc_term
   import sec_ecc_pkg::*;
#(
   parameter int GROUP_W = 12,
   localparam int OFS_W  = GROUP_W - BIT_IDX_W
) (
   input  logic [OFS_W-1:0]   ofs,
   input  logic [BYTE_W-1:0]  data,
   output logic [GROUP_W-1:0] t_true,
   output logic [GROUP_W-1:0] t_cmpl
);

   logic [GROUP_W-1:0] part_true [BYTE_W];
   logic [GROUP_W-1:0] part_cmpl [BYTE_W];

   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      logic [GROUP_W-1:0] addr;
      assign addr         = {ofs, BIT_IDX_W'(b)};
      assign part_true[b] = data[b] ? addr  : '0;
      assign part_cmpl[b] = data[b] ? ~addr : '0;
   end

   always_comb begin
      t_true = '0;
      t_cmpl = '0;
      for (int b = 0; b < BYTE_W; b++) begin
         t_true = t_true ^ part_true[b];
         t_cmpl = t_cmpl ^ part_cmpl[b];
      end
   end

endmodule

// File: rtl/sec_ecc_accum.sv
// Byte counter and the two parity-group registers.
module sec_ecc_accum
   import sec_ecc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int GROUP_W      = 12,
   localparam int OFS_W       = GROUP_W - BIT_IDX_W,
   localparam int CNT_W       = $clog2(SECTOR_BYTES) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               in_valid,
   input  logic [BYTE_W-1:0]  in_byte,
   output logic [GROUP_W-1:0] grp_true,
   output logic [GROUP_W-1:0] grp_cmpl,
   output logic               full
);

   logic [CNT_W-1:0]   cnt_q;
   logic [GROUP_W-1:0] true_q, cmpl_q;
   logic [GROUP_W-1:0] t_true, t_cmpl;
   logic [OFS_W-1:0]   cur_ofs;
   logic               accept;

   assign full    = (cnt_q == CNT_W'(SECTOR_BYTES));
   assign accept  = in_valid && !full && !clear;
   assign cur_ofs = OFS_W'(cnt_q);

   sec_ecc_term #(.GROUP_W(GROUP_W)) u_term (
      .ofs    (cur_ofs),
      .data   (in_byte),
      .t_true (t_true),
      .t_cmpl (t_cmpl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         true_q <= '0;
         cmpl_q <= '0;
      end else if (clear) begin
         cnt_q  <= '0;
         true_q <= '0;
         cmpl_q <= '0;
      end else if (accept) begin
         cnt_q  <= cnt_q + 1'b1;
         true_q <= true_q ^ t_true;
         cmpl_q <= cmpl_q ^ t_cmpl;
      end
   end

   assign grp_true = true_q;
   assign grp_cmpl = cmpl_q;

endmodule

// File: rtl/sec_ecc_classify.sv
// Compares calculated and stored codes and locates a single data-bit fault.
module sec_ecc_classify
   import sec_ecc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int GROUP_W      = 12,
   localparam int CODE_W      = 2 * GROUP_W,
   localparam int OFS_W       = GROUP_W - BIT_IDX_W
) (
   input  logic [CODE_W-1:0]    calc_code,
   input  logic [CODE_W-1:0]    stored_code,
   output ecc_res_e             verdict,
   output logic [OFS_W-1:0]     loc_byte,
   output logic [BIT_IDX_W-1:0] loc_bit
);

   logic [CODE_W-1:0]  diff;
   logic [GROUP_W-1:0] d_hi, d_lo;
   logic [OFS_W-1:0]   d_ofs;
   logic               pair_ok, in_range, lone_bit;

   assign diff     = calc_code ^ stored_code;
   assign d_hi     = diff[CODE_W-1:GROUP_W];
   assign d_lo     = diff[GROUP_W-1:0];
   assign d_ofs    = d_hi[GROUP_W-1:BIT_IDX_W];
   assign pair_ok  = ((d_hi ^ d_lo) == '1);
   assign in_range = ({1'b0, d_ofs} < (OFS_W+1)'(SECTOR_BYTES));
   assign lone_bit = (diff != '0) && ((diff & (diff - 1'b1)) == '0);

   always_comb begin
      verdict  = RES_FATAL;
      loc_byte = '0;
      loc_bit  = '0;
      if (diff == '0) begin
         verdict = RES_CLEAN;
      end else if (pair_ok) begin
         if (in_range) begin
            verdict  = RES_FIXED;
            loc_byte = d_ofs;
            loc_bit  = d_hi[BIT_IDX_W-1:0];
         end
      end else if (lone_bit) begin
         verdict = RES_CODE_HIT;
      end
   end

endmodule

// File: rtl/sec_ecc_engine.sv
module sec_ecc_engine
   import sec_ecc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int GROUP_W      = 12,
   parameter bit ERASED_CLEAN = 1'b1,
   localparam int CODE_W      = 2 * GROUP_W,
   localparam int OFS_W       = GROUP_W - BIT_IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 take,
   input  logic                 in_valid,
   input  logic [BYTE_W-1:0]    in_byte,
   input  logic [CODE_W-1:0]    stored_code,
   output logic [CODE_W-1:0]    calc_code,
   output logic                 sector_done,
   output logic [1:0]           result,
   output logic [OFS_W-1:0]     fix_byte,
   output logic [BIT_IDX_W-1:0] fix_bit
);

   if ((SECTOR_BYTES < 2) || ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0)) begin : g_bad_size
      $error("SECTOR_BYTES must be a power of two of at least 2");
   end
   if (GROUP_W < $clog2(SECTOR_BYTES) + BIT_IDX_W) begin : g_bad_group
      $error("GROUP_W too narrow to address every bit of the sector");
   end

   logic [GROUP_W-1:0] grp_true, grp_cmpl;
   logic [CODE_W-1:0]  packed_code;
   ecc_res_e           verdict;

   sec_ecc_accum #(
      .SECTOR_BYTES (SECTOR_BYTES),
      .GROUP_W      (GROUP_W)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start | take),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .grp_true (grp_true),
      .grp_cmpl (grp_cmpl),
      .full     (sector_done)
   );

   assign packed_code = {grp_true, grp_cmpl};

   if (ERASED_CLEAN) begin : g_inv
      assign calc_code = ~packed_code;
   end else begin : g_raw
      assign calc_code = packed_code;
   end

   sec_ecc_classify #(
      .SECTOR_BYTES (SECTOR_BYTES),
      .GROUP_W      (GROUP_W)
   ) u_class (
      .calc_code   (calc_code),
      .stored_code (stored_code),
      .verdict     (verdict),
      .loc_byte    (fix_byte),
      .loc_bit     (fix_bit)
   );

   assign result = verdict;

endmodule

// File: rtl/sec_ecc_engine_chk.sv
module sec_ecc_engine_chk #(
   parameter int SECTOR_BYTES = 512,
   parameter int GROUP_W      = 12,
   parameter bit ERASED_CLEAN = 1'b1,
   localparam int CODE_W      = 2 * GROUP_W,
   localparam int OFS_W       = GROUP_W - 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              take,
   input logic              in_valid,
   input logic [CODE_W-1:0] stored_code,
   input logic [CODE_W-1:0] calc_code,
   input logic              sector_done,
   input logic [1:0]        result,
   input logic [OFS_W-1:0]  fix_byte,
   input logic [2:0]        fix_bit
);

   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sector_done && !start && !take) |=> ($stable(calc_code) && sector_done));

   // R4
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sector_done) |-> $past(in_valid));

   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start || take) |=> (!sector_done && calc_code == {CODE_W{ERASED_CLEAN}}));

   // R6
   clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_code == stored_code) |-> (result == 2'd0));

   // R9
   code_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(calc_code ^ stored_code) == 1) |-> (result == 2'd2));

   // R10
   loc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result != 2'd1) |-> (fix_byte == '0 && fix_bit == '0));

endmodule

bind sec_ecc_engine sec_ecc_engine_chk #(
   .SECTOR_BYTES (SECTOR_BYTES),
   .GROUP_W      (GROUP_W),
   .ERASED_CLEAN (ERASED_CLEAN)
) u_chk (.*);

// File: tb/tb_sec_ecc_engine.sv
module tb_sec_ecc_engine;

   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  seed;
      logic        flip_en;
      logic [8:0]  flip_ofs;
      logic [2:0]  flip_bit;
      logic [23:0] code_xor;
      logic [1:0]  exp_res;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 8'h00, 1'b0, 9'd0,   3'd0, 24'h000000, 2'd0},  // erased, clean
      '{2'd2, 8'h00, 1'b0, 9'd0,   3'd0, 24'h000000, 2'd0},  // ramp, clean
      '{2'd3, 8'h5A, 1'b1, 9'd0,   3'd0, 24'h000000, 2'd1},  // first bit
      '{2'd3, 8'h13, 1'b1, 9'd511, 3'd7, 24'h000000, 2'd1},  // last bit
      '{2'd0, 8'h00, 1'b1, 9'd300, 3'd3, 24'h000000, 2'd1},  // zeros, mid
      '{2'd2, 8'hA5, 1'b0, 9'd0,   3'd0, 24'h000001, 2'd2},  // code lsb hit
      '{2'd3, 8'h77, 1'b0, 9'd0,   3'd0, 24'h800000, 2'd2},  // code msb hit
      '{2'd2, 8'h3C, 1'b0, 9'd0,   3'd0, 24'h000003, 2'd3},  // two code bits
      '{2'd3, 8'h21, 1'b1, 9'd77,  3'd5, 24'h000010, 2'd3}   // data + code
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, take = 1'b0, in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic [23:0] stored_code = 24'hFFFFFF;
   logic [23:0] calc_code;
   logic        sector_done;
   logic [1:0]  result;
   logic [8:0]  fix_byte;
   logic [2:0]  fix_bit;

   logic        s_start = 1'b0, s_valid = 1'b0;
   logic [7:0]  s_byte = '0;
   logic [23:0] s_stored = 24'hFFFFFF;
   logic [23:0] s_calc;
   logic        s_done;
   logic [1:0]  s_result;
   logic [8:0]  s_fix_byte;
   logic [2:0]  s_fix_bit;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sec_ecc_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .take(take),
      .in_valid(in_valid), .in_byte(in_byte), .stored_code(stored_code),
      .calc_code(calc_code), .sector_done(sector_done), .result(result),
      .fix_byte(fix_byte), .fix_bit(fix_bit)
   );

   sec_ecc_engine #(.SECTOR_BYTES(256), .GROUP_W(12)) dut_short (
      .clk(clk), .rst_n(rst_n), .start(s_start), .take(1'b0),
      .in_valid(s_valid), .in_byte(s_byte), .stored_code(s_stored),
      .calc_code(s_calc), .sector_done(s_done), .result(s_result),
      .fix_byte(s_fix_byte), .fix_bit(s_fix_bit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] gen_byte(input logic [1:0] kind, input logic [7:0] seed, input int i);
      case (kind)
         2'd0:    return 8'h00;
         2'd1:    return 8'hFF;
         2'd2:    return 8'(i) ^ seed;
         default: return 8'(i * 37) + seed;
      endcase
   endfunction

   function automatic logic [7:0] sent_byte(input vec_t v, input int i);
      logic [7:0] d;
      d = gen_byte(v.kind, v.seed, i);
      if (v.flip_en && i == int'(v.flip_ofs)) d[v.flip_bit] = ~d[v.flip_bit];
      return d;
   endfunction

   // Code per R2: XOR of bit addresses of ones, and of their complements, inverted
   function automatic logic [23:0] ref_code(input vec_t v, input bit with_flip);
      logic [11:0] h, l, a;
      logic [7:0]  d;
      h = '0;
      l = '0;
      for (int i = 0; i < 512; i++) begin
         d = with_flip ? sent_byte(v, i) : gen_byte(v.kind, v.seed, i);
         for (int b = 0; b < 8; b++) begin
            if (d[b]) begin
               a = 12'(i * 8 + b);
               h = h ^ a;
               l = l ^ ~a;
            end
         end
      end
      return ~{h, l};
   endfunction

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 done", 32'(sector_done), 32'd0);
      chk("R1 code", 32'(calc_code), 32'hFFFFFF);

      for (int k = 0; k < NV; k++) begin
         logic [23:0] exp_code;
         pulse_start();
         exp_code = ref_code(VECS[k], 1'b1);
         stored_code = ref_code(VECS[k], 1'b0) ^ VECS[k].code_xor;
         for (int i = 0; i < 512; i++) begin
            in_valid = 1'b1;
            in_byte  = sent_byte(VECS[k], i);
            @(negedge clk);
         end
         in_valid = 1'b0;
         chk("R4 done", 32'(sector_done), 32'd1);
         chk("R2 code", 32'(calc_code), 32'(exp_code));
         if (k == 0) chk("R3 erased", 32'(calc_code), 32'hFFFFFF);
         // R6 R7 R9 R10 verdicts from table
         chk("R6/R7/R9/R10 result", 32'(result), 32'(VECS[k].exp_res));
         chk("R7 fix_byte", 32'(fix_byte), (VECS[k].exp_res == 2'd1) ? 32'(VECS[k].flip_ofs) : 32'd0);
         chk("R7 fix_bit",  32'(fix_bit),  (VECS[k].exp_res == 2'd1) ? 32'(VECS[k].flip_bit) : 32'd0);
      end

      // R4: extra bytes after a full sector are ignored
      begin
         logic [23:0] held;
         held = calc_code;
         for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1;
            in_byte  = 8'h5B + 8'(i);
            @(negedge clk);
         end
         in_valid = 1'b0;
         chk("R4 ignored bytes", 32'(calc_code), 32'(held));
         chk("R4 still done", 32'(sector_done), 32'd1);
      end

      // R5: take clears
      take = 1'b1;
      @(negedge clk);
      take = 1'b0;
      chk("R5 take done", 32'(sector_done), 32'd0);
      chk("R5 take code", 32'(calc_code), 32'hFFFFFF);

      // R4: done not before 512th byte (ones only at byte 0 bit 0 -> nonzero code)
      for (int i = 0; i < 511; i++) begin
         in_valid = 1'b1;
         in_byte  = (i == 0) ? 8'h01 : 8'h00;
         @(negedge clk);
      end
      in_valid = 1'b0;
      chk("R4 early done", 32'(sector_done), 32'd0);
      // bit address 0: true group 000, complement group FFF, inverted -> FFF000
      chk("R2 single bit", 32'(calc_code), 32'hFFF000);

      // R5: start with a byte in the same cycle, the byte is discarded
      @(negedge clk);
      start    = 1'b1;
      in_valid = 1'b1;
      in_byte  = 8'h80;
      @(negedge clk);
      start    = 1'b0;
      in_valid = 1'b0;
      chk("R5 start done", 32'(sector_done), 32'd0);
      chk("R5 start code", 32'(calc_code), 32'hFFFFFF);

      // R8: short-sector build, erased data, fix address out of range
      @(negedge clk);
      s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      for (int i = 0; i < 256; i++) begin
         s_valid = 1'b1;
         s_byte  = 8'hFF;
         @(negedge clk);
      end
      s_valid = 1'b0;
      chk("R3 short erased", 32'(s_calc), 32'hFFFFFF);
      s_stored = 24'hFFFFFF ^ 24'h96269D;   // offset 300, bit 2
      #1;
      chk("R8 out of range", 32'(s_result), 32'd3);
      chk("R10 out of range loc", 32'(s_fix_byte), 32'd0);
      s_stored = 24'hFFFFFF ^ 24'h321CDE;   // offset 100, bit 1
      #1;
      chk("R7 short result", 32'(s_result), 32'd1);
      chk("R7 short byte", 32'(s_fix_byte), 32'd100);
      chk("R7 short bit", 32'(s_fix_bit), 32'd1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule